// File: doc/BRIEF.md
# CPU Event Arbiter

This block decides which asynchronous event an 8-bit processor core services next. It synchronizes the active-low wait, maskable interrupt, non-maskable interrupt and bus request inputs. It qualifies the raw reset input and keeps the interrupt enable flip-flop. The core's sequencer tells it when a machine cycle ends and when an instruction ends. From these strobes the block grants the bus, raises a service request with a restart address, and tracks the halted state.

Bus requests are honoured at any machine-cycle boundary. Interrupts are considered only at an instruction boundary, or on any clock while the core is halted. The non-maskable request outranks the maskable one and always restarts at 0x0066. The maskable request restarts at a parameter address, 0x0038 by default. While the bus is granted, `bus_hiz` asks the core's pads to float and `busack_n` tells the requester it owns the bus.

Top module: `cpu_event_arbiter`

## Requirements
- R1: The internal state resets only when `rst_in` is high on two consecutive clock edges. The reset takes effect one edge later. A one-cycle pulse leaves `ie_o`, `halt_n` and `busack_n` unchanged. After reset, `busack_n`=1, `bus_hiz`=0, `halt_n`=1, `ie_o`=0, `svc_valid`=0 and `stall_o`=0.
- R2: `stall_o` is high in every cycle whose `wait_n` value, taken two clock edges earlier, was low. It adds one wait state per clock for as long as `wait_n` stays low.
- R3: When `instr_end` is high at an edge, the synchronized `int_n` is low, `ie_o` is 1 and no higher-priority event applies, `svc_valid` is high for the following cycle with `svc_nmi`=0 and `svc_addr`=0x0038. With `ie_o`=0 the request is not serviced.
- R4: A falling edge of the synchronized `nmi_n` is latched as pending. It is serviced at the next `instr_end` whatever `ie_o` holds, with `svc_nmi`=1 and `svc_addr`=0x0066. A low level held across several instruction ends gives exactly one service.
- R5: When both interrupt types are ready at the same instruction end, only the non-maskable one is serviced.
- R6: A synchronized low `busreq_n` is granted only at an edge where `mcyc_end` is high. From the next cycle `busack_n`=0 and `bus_hiz`=1. The grant ends one edge after the synchronized `busreq_n` returns high. No interrupt is serviced while the bus is granted.
- R7: If a bus request and a serviceable interrupt meet at the same instruction end, the bus is granted and the interrupt stays pending. It is serviced at the first instruction end after the bus is released.
- R8: `ie_set` sets and `ie_clr` clears `ie_o`. Servicing either interrupt clears `ie_o`. A non-maskable service saves the prior `ie_o`, and `ie_restore` copies it back.
- R9: A `halt_req` pulse drives `halt_n` low. It stays low until an interrupt is serviced. While halted, an acceptable interrupt is serviced without an `instr_end` strobe, and `halt_n` returns high in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_in | input | 1 | Raw active-high reset, qualified over two cycles |
| wait_n | input | 1 | Active-low memory/IO not-ready |
| int_n | input | 1 | Active-low maskable interrupt request |
| nmi_n | input | 1 | Active-low non-maskable interrupt request |
| busreq_n | input | 1 | Active-low external bus request |
| mcyc_end | input | 1 | Strobe: current machine cycle ends |
| instr_end | input | 1 | Strobe: current instruction ends |
| halt_req | input | 1 | Strobe: halt instruction executed |
| ie_set | input | 1 | Strobe: enable maskable interrupts |
| ie_clr | input | 1 | Strobe: disable maskable interrupts |
| ie_restore | input | 1 | Strobe: restore enable saved at NMI entry |
| stall_o | output | 1 | Insert a wait state this cycle |
| busack_n | output | 1 | Active-low bus grant acknowledge |
| bus_hiz | output | 1 | Float address, data and control pads |
| halt_n | output | 1 | Active-low halted indication |
| ie_o | output | 1 | Interrupt enable flip-flop |
| svc_valid | output | 1 | One-cycle interrupt service request |
| svc_nmi | output | 1 | Service is the non-maskable type |
| svc_addr | output | 16 | Restart address for the service |

## Verification
The hardest situation to reach is a bus request and a pending maskable interrupt landing on the same instruction boundary. After the bus is released, the deferred interrupt must still be serviced. The bench holds both request lines low past the synchronizer latency. It then raises `mcyc_end` and `instr_end` in the same cycle, confirms the grant with no service, and releases the bus. A later instruction-end strobe must then bring out the maskable service. The halted wake-up on a non-maskable edge with no instruction strobe is reached by polling the service output over a bounded window.

// File: rtl/cpu_event_arbiter.sv
module cpu_event_arbiter #(
  parameter logic [15:0] NMI_ADDR = 16'h0066,
  parameter logic [15:0] INT_ADDR = 16'h0038,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_in,
  input  logic        wait_n,
  input  logic        int_n,
  input  logic        nmi_n,
  input  logic        busreq_n,
  input  logic        mcyc_end,
  input  logic        instr_end,
  input  logic        halt_req,
  input  logic        ie_set,
  input  logic        ie_clr,
  input  logic        ie_restore,
  output logic        stall_o,
  output logic        busack_n,
  output logic        bus_hiz,
  output logic        halt_n,
  output logic        ie_o,
  output logic        svc_valid,
  output logic        svc_nmi,
  output logic [15:0] svc_addr
);

  localparam int NSIG = 4;

  logic rst_prev, core_rst;

  always_ff @(posedge clk) begin
    rst_prev <= rst_in;
    core_rst <= rst_in & rst_prev;
  end

  logic [NSIG-1:0] sync_q [SYNC_STAGES];
  logic [NSIG-1:0] s;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '1;
    end else begin
      sync_q[0] <= {busreq_n, nmi_n, int_n, wait_n};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s = sync_q[SYNC_STAGES-1];

  logic wait_s, int_s, nmi_s, breq_s;
  assign {breq_s, nmi_s, int_s, wait_s} = s;

  logic nmi_last, nmi_pend, granted, halted, ie, ie_save;
  logic grant_now, take, nmi_take, int_take;

  assign grant_now = mcyc_end & ~breq_s & ~granted;
  assign take      = ~granted & ~grant_now & (instr_end | halted);
  assign nmi_take  = take & nmi_pend;
  assign int_take  = take & ~nmi_pend & ~int_s & ie;

  always_ff @(posedge clk) begin
    if (core_rst) begin
      nmi_last  <= 1'b1;
      nmi_pend  <= 1'b0;
      granted   <= 1'b0;
      halted    <= 1'b0;
      ie        <= 1'b0;
      ie_save   <= 1'b0;
      svc_valid <= 1'b0;
      svc_nmi   <= 1'b0;
      svc_addr  <= '0;
    end else begin
      nmi_last <= nmi_s;
      if (nmi_take)                 nmi_pend <= 1'b0;
      else if (nmi_last & ~nmi_s)   nmi_pend <= 1'b1;

      if (grant_now)                granted <= 1'b1;
      else if (granted & breq_s)    granted <= 1'b0;

      if (nmi_take | int_take)      halted <= 1'b0;
      else if (halt_req)            halted <= 1'b1;

      if (nmi_take) begin
        ie_save <= ie;
        ie      <= 1'b0;
      end else if (int_take) begin
        ie      <= 1'b0;
      end else if (ie_restore) begin
        ie      <= ie_save;
      end else if (ie_set) begin
        ie      <= 1'b1;
      end else if (ie_clr) begin
        ie      <= 1'b0;
      end

      svc_valid <= nmi_take | int_take;
      svc_nmi   <= nmi_take;
      if (nmi_take | int_take) svc_addr <= nmi_take ? NMI_ADDR : INT_ADDR;
    end
  end

  assign stall_o  = ~wait_s;
  assign busack_n = ~granted;
  assign bus_hiz  = granted;
  assign halt_n   = ~halted;
  assign ie_o     = ie;

  AST_RST_QUAL: assert property (@(posedge clk) core_rst |-> $past(rst_in)); // R1
  AST_STALL_FROM_WAIT: assert property (@(posedge clk) disable iff (core_rst)
    stall_o |-> !$past(wait_n, 2)); // R2
  AST_INT_NEEDS_IE: assert property (@(posedge clk) disable iff (core_rst)
    (svc_valid && !svc_nmi) |-> $past(ie_o)); // R3
  AST_NO_SVC_IN_GRANT: assert property (@(posedge clk) disable iff (core_rst)
    svc_valid |-> busack_n); // R6
  AST_GRANT_AT_MCYC: assert property (@(posedge clk) disable iff (core_rst)
    $fell(busack_n) |-> $past(mcyc_end)); // R6
  AST_SVC_CLEARS_IE: assert property (@(posedge clk) disable iff (core_rst)
    svc_valid |-> !ie_o); // R8
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (core_rst)
    !halt_n |=> (!halt_n || svc_valid)); // R9

endmodule

// File: tb/cpu_event_arbiter_tb_top.sv
`timescale 1ns/1ps
module cpu_event_arbiter_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_in = 1'b1, wait_n = 1'b1, int_n = 1'b1, nmi_n = 1'b1, busreq_n = 1'b1;
  logic mcyc_end = 1'b0, instr_end = 1'b0, halt_req = 1'b0;
  logic ie_set = 1'b0, ie_clr = 1'b0, ie_restore = 1'b0;
  logic stall_o, busack_n, bus_hiz, halt_n, ie_o, svc_valid, svc_nmi;
  logic [15:0] svc_addr;

  cpu_event_arbiter dut_i (
    .clk(clk), .rst_in(rst_in), .wait_n(wait_n), .int_n(int_n), .nmi_n(nmi_n),
    .busreq_n(busreq_n), .mcyc_end(mcyc_end), .instr_end(instr_end),
    .halt_req(halt_req), .ie_set(ie_set), .ie_clr(ie_clr), .ie_restore(ie_restore),
    .stall_o(stall_o), .busack_n(busack_n), .bus_hiz(bus_hiz), .halt_n(halt_n),
    .ie_o(ie_o), .svc_valid(svc_valid), .svc_nmi(svc_nmi), .svc_addr(svc_addr)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_ie(bit en);
    if (en) ie_set = 1'b1; else ie_clr = 1'b1;
    step();
    ie_set = 1'b0; ie_clr = 1'b0;
  endtask

  task automatic pulse_instr();
    instr_end = 1'b1;
    step();
    instr_end = 1'b0;
  endtask

  // {ie, int_low, nmi_edge, exp_valid, exp_nmi}
  localparam logic [4:0] VEC [8] = '{
    5'b00000, 5'b11010, 5'b01000, 5'b00111,
    5'b11111, 5'b10111, 5'b10000, 5'b11010
  };

  initial begin
    step(3);
    rst_in = 1'b0;
    step(2);
    // R1 reset state
    chk("R1 busack_n", busack_n, 1); chk("R1 bus_hiz", bus_hiz, 0);
    chk("R1 halt_n", halt_n, 1);     chk("R1 ie_o", ie_o, 0);
    chk("R1 svc_valid", svc_valid, 0); chk("R1 stall_o", stall_o, 0);

    // R8 enable strobes, R1 pulse qualification
    pulse_ie(1);
    chk("R8 ie_set", ie_o, 1);
    rst_in = 1'b1; step(); rst_in = 1'b0; step(2);
    chk("R1 short pulse ignored", ie_o, 1);
    rst_in = 1'b1; step(2); rst_in = 1'b0; step();
    chk("R1 two-cycle reset", ie_o, 0);

    // R2 wait
    wait_n = 1'b0; step();
    chk("R2 stall latency", stall_o, 0);
    step();
    chk("R2 stall active", stall_o, 1);
    step(3);
    chk("R2 stall held", stall_o, 1);
    wait_n = 1'b1; step(2);
    chk("R2 stall released", stall_o, 0);

    // R3/R4/R5 vector table
    foreach (VEC[k]) begin
      pulse_ie(VEC[k][4]);
      int_n = ~VEC[k][3];
      if (VEC[k][2]) nmi_n = 1'b0;
      step(3);
      nmi_n = 1'b1;
      pulse_instr();
      chk($sformatf("R3 R4 R5 vec%0d valid", k), svc_valid, VEC[k][1]);
      if (VEC[k][1]) begin
        chk($sformatf("R5 vec%0d kind", k), svc_nmi, VEC[k][0]);
        chk($sformatf("R3 R4 vec%0d addr", k), svc_addr, VEC[k][0] ? 32'h66 : 32'h38);
        chk($sformatf("R8 vec%0d ie cleared", k), ie_o, 0);
      end
      int_n = 1'b1;
      step(3);
    end

    // R4 held low NMI gives one service
    begin
      int cnt = 0;
      pulse_ie(0);
      nmi_n = 1'b0; step(3);
      for (int j = 0; j < 3; j++) begin
        pulse_instr();
        if (svc_valid) cnt++;
        step();
      end
      chk("R4 single service on held level", cnt, 1);
      nmi_n = 1'b1; step(3);
    end

    // R8 save and restore on NMI
    pulse_ie(1);
    nmi_n = 1'b0; step(3); nmi_n = 1'b1;
    pulse_instr();
    chk("R8 nmi service", svc_nmi, 1);
    chk("R8 ie cleared by nmi", ie_o, 0);
    ie_restore = 1'b1; step(); ie_restore = 1'b0;
    chk("R8 ie restored", ie_o, 1);
    pulse_ie(0);
    step(2);

    // R6 bus grant only at machine-cycle end
    busreq_n = 1'b0; step(4);
    chk("R6 no grant without mcyc_end", busack_n, 1);
    mcyc_end = 1'b1; step(); mcyc_end = 1'b0;
    chk("R6 busack_n granted", busack_n, 0);
    chk("R6 bus_hiz granted", bus_hiz, 1);
    pulse_ie(1);
    int_n = 1'b0; step(3);
    pulse_instr();
    chk("R6 no service while granted", svc_valid, 0);
    int_n = 1'b1;
    busreq_n = 1'b1; step(3);
    chk("R6 released", busack_n, 1);
    chk("R6 pads driven", bus_hiz, 0);
    step(2);

    // R7 bus and interrupt on the same boundary
    int_n = 1'b0; busreq_n = 1'b0; step(3);
    mcyc_end = 1'b1; instr_end = 1'b1; step();
    mcyc_end = 1'b0; instr_end = 1'b0;
    chk("R7 bus granted first", busack_n, 0);
    chk("R7 no service on shared boundary", svc_valid, 0);
    busreq_n = 1'b1; step(3);
    chk("R7 bus released", busack_n, 1);
    pulse_instr();
    chk("R7 deferred interrupt served", svc_valid, 1);
    chk("R7 deferred kind", svc_nmi, 0);
    int_n = 1'b1; step(3);

    // R9 halt
    begin
      int seen = 0;
      bit got = 1'b0, kind = 1'b0;
      pulse_ie(0);
      halt_req = 1'b1; step(); halt_req = 1'b0;
      chk("R9 halt_n low", halt_n, 0);
      int_n = 1'b0;
      for (int j = 0; j < 5; j++) begin
        step();
        if (svc_valid) seen++;
      end
      chk("R9 masked int ignored in halt", seen, 0);
      chk("R9 still halted", halt_n, 0);
      int_n = 1'b1;
      nmi_n = 1'b0;
      for (int j = 0; j < 8; j++) begin
        step();
        if (svc_valid && !got) begin got = 1'b1; kind = svc_nmi; end
      end
      chk("R9 nmi wakes halt", got, 1);
      chk("R9 wake kind", kind, 1);
      chk("R9 halt_n released", halt_n, 1);
      nmi_n = 1'b1; step(3);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5ns * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule